// File: doc/BRIEF.md
# Space-Vector Dwell-Time Calculator

This block turns one reference request into the timing plan for one sampling period of a two-level three-phase inverter. Each request carries the reference angle as an unsigned fraction of a full turn, a modulation index and the sampling-period length in clock ticks. The block finds which of the six 60-degree sectors holds the reference and folds the angle into that sector's window. It then returns the tick counts for the leading active vector (Ta), the trailing active vector (Tb) and the zero vector (T0).

Sines come from a quarter-wave table that is computed at elaboration. The two active times are products of the period, the index and a sine, rounded to whole ticks. When the reference lies outside the hexagon, both active times are scaled back so that they fill the period exactly. A flag then marks the result as overmodulated. Requests and results each pass through their own valid/ready pair. Only one request is in flight at a time, and the latency is fixed.

Top module: `svpwm_dwell`

## Requirements
- R1: With p = angle·6 for a 16-bit angle, `sector_o` = floor(p / 65536) + 1. Sector 1 begins at angle 0, and the sector number rises counterclockwise up to 6.
- R2: The in-sector position is r = p mod 65536. Its upper 8 bits, idx = r[15:8], are the truncated reduced angle θ' = idx·60°/256. The leading vector uses the sine of (256 − idx)·60°/256.
- R3: When not overmodulated, `ta_o` equals Ts·m·sin(60° − θ') to within one tick, where m = `mod_idx_i`/32768 (unsigned Q1.15).
- R4: When not overmodulated, `tb_o` equals Ts·m·sin(θ') to within one tick.
- R5: `ta_o + tb_o + t0_o` equals the `ts_i` of the request exactly.
- R6: For idx = 128, `ta_o` equals `tb_o` exactly. For idx = 0, `tb_o` is 0.
- R7: When the rounded Ta + Tb exceeds Ts, the block sets `ta_o` = round(Ts·Ta/(Ta+Tb)), `tb_o` = Ts − `ta_o`, `t0_o` = 0 and `ovm_o` = 1. Otherwise `ovm_o` = 0.
- R8: After reset, `req_ready_o` = 1 and `res_valid_o` = 0. `req_ready_o` stays low from the acceptance of a request until its result is taken.
- R9: While `res_valid_o` is high and `res_ready_i` is low, every result output holds its value.
- R10: `res_valid_o` rises exactly 2·TS_W+6 clock cycles after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| angle_i | input | ANG_W | Reference angle, fraction of a turn |
| mod_idx_i | input | MI_W | Modulation index, unsigned Q1.(MI_W-1) |
| ts_i | input | TS_W | Sampling period in ticks |
| res_valid_o | output | 1 | Result present |
| res_ready_i | input | 1 | Consumer takes the result |
| sector_o | output | 3 | Sector number 1..6 |
| ta_o | output | TS_W | Leading active-vector ticks |
| tb_o | output | TS_W | Trailing active-vector ticks |
| t0_o | output | TS_W | Zero-vector ticks |
| ovm_o | output | 1 | Overmodulation clamp applied |

## Verification
The bench builds the block with its defaults: a 16-bit angle, index and period, and 8 bits of in-sector resolution. With the full 16-bit period, periods up to 65535 ticks push the widest products through the multiply chain. The 8-bit resolution makes the exact sector midpoint (idx 128) and the exact sector start (idx 0) reachable from integer angles in several sectors. A modulation index up to almost 2 reaches deep overmodulation, so the proportional clamp is exercised away from its threshold. A random consumer stall exercises output holding.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  localparam int SIN_W = 16;
  localparam longint PI_Q30 = 64'sd3373259426;

  // sin(idx * (pi/2) / span) in Q1.15, integer Taylor series in Q30
  function automatic logic [SIN_W-1:0] sin_q15(input int idx, input int span);
    longint x, term, acc, q;
    x    = (PI_Q30 * longint'(idx)) / longint'(2 * span);
    term = x;
    acc  = x;
    for (int n = 1; n <= 8; n++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -term / longint'(2 * n * (2 * n + 1));
      acc  = acc + term;
    end
    q = (acc + 64'sd16384) >>> 15;
    if (q > 64'sd32767) q = 64'sd32767;
    if (q < 64'sd0) q = 64'sd0;
    return q[SIN_W-1:0];
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE, ST_LUT, ST_MUL, ST_CHK, ST_DIV, ST_OUT
  } dw_state_e;

endpackage

// File: rtl/svpwm_sector.sv
module svpwm_sector #(
  parameter int ANG_W    = 16,
  parameter int LUT_BITS = 8
) (
  input  logic [ANG_W-1:0]  angle_i,
  output logic [2:0]        sector_o,
  output logic [LUT_BITS:0] idx_lead_o,
  output logic [LUT_BITS:0] idx_trail_o
);
  localparam int PW = ANG_W + 3;
  localparam logic [LUT_BITS:0] FULL = {1'b1, {LUT_BITS{1'b0}}};

  logic [PW-1:0] prod;

  // angle * 6: integer part is sector-1, fraction is position in sector
  assign prod        = (PW'(angle_i) << 2) + (PW'(angle_i) << 1);
  assign sector_o    = 3'(prod >> ANG_W) + 3'd1;
  assign idx_trail_o = {1'b0, LUT_BITS'(prod >> (ANG_W - LUT_BITS))};
  assign idx_lead_o  = FULL - idx_trail_o;
endmodule

// File: rtl/svpwm_sine_rom.sv
module svpwm_sine_rom import svpwm_pkg::*; #(
  parameter int LUT_BITS = 8
) (
  input  logic [LUT_BITS:0] addr_i,
  output logic [SIN_W-1:0]  data_o
);
  // 60 deg spans 2**LUT_BITS steps, so 90 deg spans 1.5x that
  localparam int SPAN  = 3 * (2 ** (LUT_BITS - 1));
  localparam int DEPTH = SPAN + 1;

  logic [SIN_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    assign tbl[i] = sin_q15(i, SPAN);
  end

  assign data_o = tbl[addr_i];
endmodule

// File: rtl/svpwm_divu.sv
module svpwm_divu #(
  parameter int NUM_W = 34,
  parameter int DEN_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int CW = $clog2(NUM_W + 1);

  logic             busy;
  logic [CW-1:0]    cnt;
  logic [DEN_W-1:0] rem, rem_nx, den_q;
  logic [NUM_W-1:0] quot;
  logic [DEN_W:0]   trial;
  logic             qbit;

  always_comb begin
    trial  = {rem, quot[NUM_W-1]};
    qbit   = trial >= {1'b0, den_q};
    rem_nx = qbit ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy  <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      quot  <= '0;
      den_q <= '0;
    end else if (start_i) begin
      busy  <= 1'b1;
      cnt   <= CW'(NUM_W);
      rem   <= '0;
      quot  <= num_i;
      den_q <= den_i;
    end else if (busy) begin
      if (cnt != '0) begin
        rem  <= rem_nx;
        quot <= {quot[NUM_W-2:0], qbit};
        cnt  <= cnt - 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assign done_o = busy && (cnt == '0);
  assign quot_o = quot;
endmodule

// File: rtl/svpwm_dwell.sv
module svpwm_dwell import svpwm_pkg::*; #(
  parameter int ANG_W    = 16,
  parameter int MI_W     = 16,
  parameter int TS_W     = 16,
  parameter int LUT_BITS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [ANG_W-1:0] angle_i,
  input  logic [MI_W-1:0]  mod_idx_i,
  input  logic [TS_W-1:0]  ts_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [2:0]       sector_o,
  output logic [TS_W-1:0]  ta_o,
  output logic [TS_W-1:0]  tb_o,
  output logic [TS_W-1:0]  t0_o,
  output logic             ovm_o
);
  localparam int TA_W  = TS_W + 1;
  localparam int SUM_W = TS_W + 2;
  localparam int NUM_W = 2 * TS_W + 2;
  localparam int PR_W  = MI_W + SIN_W;
  localparam int SH    = (MI_W - 1) + (SIN_W - 1);
  localparam int WF    = TS_W + PR_W;
  localparam logic [WF-1:0] RND = WF'(1) << (SH - 1);

  dw_state_e state;

  logic [ANG_W-1:0]  ang_q;
  logic [MI_W-1:0]   mi_q;
  logic [TS_W-1:0]   ts_q;
  logic [PR_W-1:0]   pa_q, pb_q, pa_nx, pb_nx;
  logic [TA_W-1:0]   ta_q, tb_q, ta_nx, tb_nx;
  logic [WF-1:0]     ta_full, tb_full;
  logic [SUM_W-1:0]  sum;
  logic [NUM_W-1:0]  num;
  logic              over_q;
  logic [2:0]        sector_c;
  logic [LUT_BITS:0] idx_lead, idx_trail;
  logic [SIN_W-1:0]  sin_lead, sin_trail;
  logic              div_done;
  logic [NUM_W-1:0]  div_quot;
  logic [TS_W-1:0]   ta_clamp;

  svpwm_sector #(.ANG_W(ANG_W), .LUT_BITS(LUT_BITS)) u_sector (
    .angle_i    (ang_q),
    .sector_o   (sector_c),
    .idx_lead_o (idx_lead),
    .idx_trail_o(idx_trail)
  );

  svpwm_sine_rom #(.LUT_BITS(LUT_BITS)) u_rom_lead (
    .addr_i(idx_lead),
    .data_o(sin_lead)
  );

  svpwm_sine_rom #(.LUT_BITS(LUT_BITS)) u_rom_trail (
    .addr_i(idx_trail),
    .data_o(sin_trail)
  );

  always_comb begin
    pa_nx   = PR_W'(mi_q) * PR_W'(sin_lead);
    pb_nx   = PR_W'(mi_q) * PR_W'(sin_trail);
    ta_full = WF'(ts_q) * WF'(pa_q) + RND;
    tb_full = WF'(ts_q) * WF'(pb_q) + RND;
    ta_nx   = TA_W'(ta_full >> SH);
    tb_nx   = TA_W'(tb_full >> SH);
    sum     = SUM_W'(ta_q) + SUM_W'(tb_q);
    // ts*ta/sum rounded to nearest
    num     = NUM_W'(ts_q) * NUM_W'(ta_q) + NUM_W'(sum >> 1);
  end

  svpwm_divu #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(state == ST_CHK),
    .num_i  (num),
    .den_i  (sum),
    .done_o (div_done),
    .quot_o (div_quot)
  );

  assign ta_clamp = TS_W'(div_quot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      ang_q    <= '0;
      mi_q     <= '0;
      ts_q     <= '0;
      pa_q     <= '0;
      pb_q     <= '0;
      ta_q     <= '0;
      tb_q     <= '0;
      over_q   <= 1'b0;
      sector_o <= 3'd1;
      ta_o     <= '0;
      tb_o     <= '0;
      t0_o     <= '0;
      ovm_o    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid_i) begin
          ang_q <= angle_i;
          mi_q  <= mod_idx_i;
          ts_q  <= ts_i;
          state <= ST_LUT;
        end
        ST_LUT: begin
          pa_q  <= pa_nx;
          pb_q  <= pb_nx;
          state <= ST_MUL;
        end
        ST_MUL: begin
          ta_q  <= ta_nx;
          tb_q  <= tb_nx;
          state <= ST_CHK;
        end
        ST_CHK: begin
          over_q <= sum > SUM_W'(ts_q);
          state  <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          sector_o <= sector_c;
          ovm_o    <= over_q;
          if (over_q) begin
            ta_o <= ta_clamp;
            tb_o <= ts_q - ta_clamp;
            t0_o <= '0;
          end else begin
            ta_o <= TS_W'(ta_q);
            tb_o <= TS_W'(tb_q);
            t0_o <= ts_q - TS_W'(ta_q) - TS_W'(tb_q);
          end
          state <= ST_OUT;
        end
        ST_OUT: if (res_ready_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state == ST_IDLE);
  assign res_valid_o = (state == ST_OUT);
endmodule

// File: rtl/svpwm_dwell_chk.sv
module svpwm_dwell_chk #(
  parameter int TS_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [TS_W-1:0] ts_i,
  input logic            res_valid_o,
  input logic            res_ready_i,
  input logic [2:0]      sector_o,
  input logic [TS_W-1:0] ta_o,
  input logic [TS_W-1:0] tb_o,
  input logic [TS_W-1:0] t0_o,
  input logic            ovm_o
);
  localparam int LAT = 2 * TS_W + 7;
  localparam int CW  = $clog2(LAT + 2) + 1;

  logic [TS_W-1:0] ts_cap;
  logic [CW-1:0]   cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_cap <= '0;
      cyc    <= '0;
    end else if (req_valid_i && req_ready_o) begin
      ts_cap <= ts_i;
      cyc    <= CW'(1);
    end else if (cyc != '0 && !res_valid_o) begin
      cyc <= cyc + 1'b1;
    end
  end

  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !req_ready_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(ta_o) && $stable(tb_o)
      && $stable(t0_o) && $stable(sector_o) && $stable(ovm_o));

  p_sum_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ((TS_W+2)'(ta_o) + (TS_W+2)'(tb_o) + (TS_W+2)'(t0_o)) == (TS_W+2)'(ts_cap));

  p_sector_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (sector_o >= 3'd1) && (sector_o <= 3'd6));

  p_clamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && ovm_o |-> t0_o == '0);

  p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> cyc == CW'(LAT));
endmodule

bind svpwm_dwell svpwm_dwell_chk #(.TS_W(TS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .ts_i       (ts_i),
  .res_valid_o(res_valid_o),
  .res_ready_i(res_ready_i),
  .sector_o   (sector_o),
  .ta_o       (ta_o),
  .tb_o       (tb_o),
  .t0_o       (t0_o),
  .ovm_o      (ovm_o)
);

// File: tb/svpwm_dwell_test.sv
module svpwm_dwell_test;
  localparam int TS_W = 16;
  localparam int LAT  = 2 * TS_W + 6;
  localparam real PI  = 3.14159265358979;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_ready_o;
  logic [15:0] angle_i = '0;
  logic [15:0] mod_idx_i = '0;
  logic [TS_W-1:0] ts_i = '0;
  logic res_valid_o;
  logic res_ready_i = 1'b0;
  logic [2:0] sector_o;
  logic [TS_W-1:0] ta_o, tb_o, t0_o;
  logic ovm_o;

  always #4 clk_i = ~clk_i;

  svpwm_dwell uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .angle_i(angle_i), .mod_idx_i(mod_idx_i), .ts_i(ts_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
    .sector_o(sector_o), .ta_o(ta_o), .tb_o(tb_o), .t0_o(t0_o), .ovm_o(ovm_o)
  );

  typedef struct { int ang; int ma; int ts; int acc; } req_t;
  req_t q[$];

  int checks = 0, fails = 0, sent = 0, got = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0.2f exp=%0.2f", tag, act, exp);
    end
  endtask

  function automatic real rabs(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic verify(input req_t r);
    int p, k, rr, idx;
    real m, sa, sb, ta_r, tb_r, ta_e, tb_e, tol;
    bit ov;
    p    = r.ang * 6;
    k    = p / 65536;
    rr   = p % 65536;
    idx  = rr / 256;
    m    = r.ma / 32768.0;
    sa   = $sin((256 - idx) * PI / 768.0);
    sb   = $sin(idx * PI / 768.0);
    ta_r = r.ts * m * sa;
    tb_r = r.ts * m * sb;
    ov   = (ta_r + tb_r) > r.ts;
    if (ov) begin
      ta_e = r.ts * ta_r / (ta_r + tb_r);
      tb_e = r.ts - ta_e;
      tol  = 1.5;
    end else begin
      ta_e = ta_r;
      tb_e = tb_r;
      tol  = 1.0;
    end
    chk(int'(sector_o) == k + 1, "R1 sector", real'(sector_o), real'(k + 1));
    chk(rabs(real'(ta_o) - ta_e) <= tol, ov ? "R7 Ta clamp" : "R2/R3 Ta", real'(ta_o), ta_e);
    chk(rabs(real'(tb_o) - tb_e) <= tol, ov ? "R7 Tb clamp" : "R2/R4 Tb", real'(tb_o), tb_e);
    chk(int'(ta_o) + int'(tb_o) + int'(t0_o) == r.ts, "R5 sum",
        real'(int'(ta_o) + int'(tb_o) + int'(t0_o)), real'(r.ts));
    chk(ovm_o == ov, "R7 flag", real'(ovm_o), real'(ov));
    if (ov) chk(t0_o == '0, "R7 T0 zero", real'(t0_o), 0.0);
    if (idx == 128) chk(ta_o == tb_o, "R6 midpoint", real'(ta_o), real'(tb_o));
    if (idx == 0) chk(tb_o == '0, "R6 sector start", real'(tb_o), 0.0);
  endtask

  task automatic send(input int ang, input int ma, input int ts);
    req_t r;
    @(negedge clk_i);
    angle_i = ang[15:0];
    mod_idx_i = ma[15:0];
    ts_i = ts[TS_W-1:0];
    req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    r.ang = ang; r.ma = ma; r.ts = ts; r.acc = cyc;
    q.push_back(r);
    sent++;
    chk(!req_ready_o, "R8 busy", real'(req_ready_o), 0.0);
  endtask

  // monitor / scoreboard
  initial begin
    logic [15:0] lf = 16'hACE1;
    bit held = 0;
    logic [TS_W-1:0] s_ta, s_tb, s_t0;
    logic [2:0] s_sec;
    logic s_ovm;
    req_t r;
    @(posedge rst_ni);
    forever begin
      @(negedge clk_i);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (res_valid_o) begin
        if (q.size() == 0) begin
          chk(0, "R8 unexpected result", 1.0, 0.0);
          res_ready_i = 1'b1;
        end else begin
          if (held) begin
            chk(ta_o == s_ta && tb_o == s_tb && t0_o == s_t0 && sector_o == s_sec
                && ovm_o == s_ovm, "R9 hold", real'(ta_o), real'(s_ta));
          end else begin
            chk(cyc - q[0].acc == LAT, "R10 latency", real'(cyc - q[0].acc), real'(LAT));
          end
          if (lf[0] && lf[3]) begin
            res_ready_i = 1'b0;
            held = 1;
            s_ta = ta_o; s_tb = tb_o; s_t0 = t0_o; s_sec = sector_o; s_ovm = ovm_o;
          end else begin
            res_ready_i = 1'b1;
            r = q.pop_front();
            verify(r);
            got++;
            held = 0;
          end
        end
      end else begin
        res_ready_i = 1'b0;
        held = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", got, sent);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int x;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R8 reset ready", real'(req_ready_o), 1.0);
    chk(res_valid_o == 1'b0, "R8 reset valid", real'(res_valid_o), 0.0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R8 idle ready", real'(req_ready_o), 1.0);

    send(0, 26214, 1000);       // sector 1 start, R6
    send(5462, 26214, 1000);    // sector 1 midpoint, R6
    send(10923, 26214, 2000);   // sector 2 start
    send(38230, 30000, 4000);   // sector 4 midpoint
    send(65535, 20000, 65535);  // sector 6 end, widest period
    send(20000, 0, 500);        // zero index: all zero-vector
    send(5462, 49152, 1000);    // R7 symmetric clamp
    send(1000, 60000, 3000);    // R7 clamp near sector start
    send(50000, 40000, 800);    // R7 clamp in sector 5

    x = 12345;
    for (int i = 0; i < 40; i++) begin
      x = (x * 1103515245 + 12345) & 32'h7fffffff;
      send(x % 65536, 1000 + (x / 65536) % 26000, 100 + (x / 7) % 60000);
    end

    while (got != sent) @(negedge clk_i);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule